// File: doc/BRIEF.md
# Capture and Pulse-Width Timer Channel

This channel watches one external signal and timestamps it against a free-running counter that another block owns and feeds in. The signal first passes through a chain of synchronizing flops. An edge detector then picks out the edges the channel should react to, and the configured action turns each edge into a result.

There are three actions. A plain capture stores the counter value at each selected edge. A period measurement stores the counter distance between two consecutive selected edges. A pulse-width measurement stores how long the signal stayed high or low. The capture register and the pulse-width register are separate outputs. An interrupt flag rises whenever a result lands.

Software reaches the capture register through two views, and the system bus logic reports accesses to the block as one-cycle strobes. One view clears the flag when it is accessed; the other leaves the flag untouched.

Top module: `cap_pw_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cap_val_o`, `pulse_val_o` and `irq_o` become zero, and any measurement in progress is forgotten.
- R2: When `sig_i` changes before clock edge k, the resulting capture takes the value `count_i` holds at edge k+SYNC_STAGES. Two edges of the same kind are never detected on consecutive clocks.
- R3: `edge_sel_i` chooses the edges: 0 rising only, 1 falling only, 2 both. The value 3 selects no edge. Edges that are not selected leave every output unchanged.
- R4: With `action_i` = 0 (plain capture), every selected edge loads `count_i` into `cap_val_o` and sets the flag. The value 3 of `action_i` is reserved and has no effect.
- R5: With `action_i` = 1 (period), each selected edge after the first loads `cap_val_o` with the current count minus the count at the previous selected edge, modulo 2^CNT_W. This holds across a counter wrap.
- R6: With `action_i` = 2 (pulse width), the edge selection names the phase. Value 0 measures the high phase (rising edge to falling edge). Value 1 measures the low phase (falling edge to rising edge). Value 2 measures every phase (each edge ends the previous phase). The width goes to `pulse_val_o`, and `cap_val_o` takes the count at the ending edge.
- R7: After reset, and after `enable_i` rises, the first edge that would start a period or pulse-width measurement only arms it. It gives no result and does not set the flag. An ending edge that arrives before any start edge is ignored.
- R8: While `enable_i` is low, neither value register changes and the flag is not set. Arming is dropped.
- R9: The flag is set in the cycle after a result lands. A `acc_clr_i` strobe clears it on the next edge. A `acc_keep_i` strobe leaves it set.
- R10: When a result lands on the same edge as an `acc_clr_i` strobe, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count_i | input | CNT_W | Free-running timer count |
| sig_i | input | 1 | Asynchronous signal to be observed |
| enable_i | input | 1 | Channel enable |
| action_i | input | 2 | 0 capture, 1 period, 2 pulse width, 3 reserved |
| edge_sel_i | input | 2 | 0 rising, 1 falling, 2 both, 3 none |
| acc_clr_i | input | 1 | Access to the capture register through the clearing view |
| acc_keep_i | input | 1 | Access to the capture register through the non-clearing view |
| cap_val_o | output | CNT_W | Captured count or measured period |
| pulse_val_o | output | CNT_W | Measured pulse width |
| irq_o | output | 1 | Capture interrupt flag |

## Verification
The bench builds the channel with its default parameters: a 24-bit count and a two-flop synchronizer. The count is driven by the bench rather than by a real timer, so it can jump to a few ticks below 2^24 and make a period measurement straddle the wrap. The reference model reads SYNC_STAGES, so the exact two-clock input latency is compared on every cycle, not just in the directed cases. Edge timing is chosen to keep each phase longer than the synchronizer delay, so that the high-phase, low-phase and both-phase widths come out as distinct known numbers.

// File: rtl/cap_pkg.sv
// Shared encodings for the capture channel.
package cap_pkg;

    typedef enum logic [1:0] {
        ACT_PLAIN  = 2'd0,
        ACT_PERIOD = 2'd1,
        ACT_PULSE  = 2'd2,
        ACT_RSVD   = 2'd3
    } cap_action_e;

    typedef enum logic [1:0] {
        EDG_RISE = 2'd0,
        EDG_FALL = 2'd1,
        EDG_BOTH = 2'd2,
        EDG_NONE = 2'd3
    } cap_edge_e;

endpackage

// File: rtl/cap_sync_edge.sv
// Synchronizer and edge detector.
// Brings an asynchronous level through STAGES flops and flags a rising or
// falling transition of the synchronized level for one clock.
// Assumes STAGES >= 2 and that the input is slow enough for a level change
// to last at least one clock.
module cap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shift_q;
    logic             level;
    logic             prev;

    // Shift the raw input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[DEPTH-2:0], sig_i};
        end
    end

    assign level  = shift_q[STAGES-1];
    assign prev   = shift_q[STAGES];
    assign rise_o = level & ~prev;
    assign fall_o = ~level & prev;

    // R2
    rise_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    // R2
    fall_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/cap_measure.sv
// Measurement engine.
// Turns detected edges into capture, period or pulse-width results against
// an external count. Reports each landed result through done_o in the
// same cycle as it is registered.
// Assumes configuration changes only while enable_i is low.
module cap_measure
    import cap_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  cap_action_e      action_i,
    input  cap_edge_e        edge_sel_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic [CNT_W-1:0] pulse_val_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] pulse_q;
    logic [CNT_W-1:0] ref_q;
    logic             arm_q;
    logic [CNT_W-1:0] delta;
    logic             sel_edge;
    logic             start_edge;
    logic             end_edge;

    // Decode which detected edges matter for the current edge setting.
    always_comb begin
        sel_edge   = 1'b0;
        start_edge = 1'b0;
        end_edge   = 1'b0;
        case (edge_sel_i)
            EDG_RISE: begin
                sel_edge   = rise_i;
                start_edge = rise_i;
                end_edge   = fall_i;
            end
            EDG_FALL: begin
                sel_edge   = fall_i;
                start_edge = fall_i;
                end_edge   = rise_i;
            end
            EDG_BOTH: begin
                sel_edge   = rise_i | fall_i;
                start_edge = rise_i | fall_i;
                end_edge   = rise_i | fall_i;
            end
            default: ;
        endcase
    end

    assign delta = count_i - ref_q;

    // Decide whether a result lands on this clock.
    always_comb begin
        done_o = 1'b0;
        if (enable_i) begin
            case (action_i)
                ACT_PLAIN:  done_o = sel_edge;
                ACT_PERIOD: done_o = sel_edge & arm_q;
                ACT_PULSE:  done_o = end_edge & arm_q;
                default:    done_o = 1'b0;
            endcase
        end
    end

    // Update result registers, reference count and arming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= '0;
            pulse_q <= '0;
            ref_q   <= '0;
            arm_q   <= 1'b0;
        end else if (!enable_i) begin
            arm_q <= 1'b0;
        end else begin
            case (action_i)
                ACT_PLAIN: begin
                    if (sel_edge) cap_q <= count_i;
                end
                ACT_PERIOD: begin
                    if (sel_edge) begin
                        if (arm_q) cap_q <= delta;
                        ref_q <= count_i;
                        arm_q <= 1'b1;
                    end
                end
                ACT_PULSE: begin
                    if (end_edge && arm_q) begin
                        pulse_q <= delta;
                        cap_q   <= count_i;
                        arm_q   <= 1'b0;
                    end
                    if (start_edge) begin
                        ref_q <= count_i;
                        arm_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cap_val_o   = cap_q;
    assign pulse_val_o = pulse_q;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> ($stable(cap_q) && $stable(pulse_q)));
    // R8
    idle_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !arm_q);
    // R7
    armed_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && action_i != ACT_PLAIN) |-> arm_q);
    // R5
    period_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && action_i == ACT_PERIOD && sel_edge) |=> arm_q);

endmodule

// File: rtl/cap_irq_flag.sv
// Capture interrupt flag.
// Sets on every landed result; a clearing access drops it, a non-clearing
// access does not. A result on the same edge as a clear wins.
module cap_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic acc_clr_i,
    input  logic acc_keep_i,
    output logic irq_o
);
    logic flag_q;

    // Track the flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (done_i) begin
            flag_q <= 1'b1;
        end else if (acc_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign irq_o = flag_q;

    // R9
    set_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> irq_o);
    // R9
    clear_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr_i && !done_i) |=> !irq_o);
    // R9
    keep_on_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && acc_keep_i && !acc_clr_i) |=> irq_o);
    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && acc_clr_i) |=> irq_o);

endmodule

// File: rtl/cap_pw_channel.sv
// Capture and pulse-width timer channel, top level.
// Synchronizes an external signal, detects its edges and records capture,
// period or pulse-width results against a count supplied from outside.
// Assumes count_i advances in the clk domain and configuration is changed
// only with enable_i low.
module cap_pw_channel
    import cap_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             sig_i,
    input  logic             enable_i,
    input  logic [1:0]       action_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             acc_clr_i,
    input  logic             acc_keep_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic [CNT_W-1:0] pulse_val_o,
    output logic             irq_o
);
    logic rise;
    logic fall;
    logic done;

    cap_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sig_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    cap_measure #(
        .CNT_W (CNT_W)
    ) u_meas (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .action_i    (cap_action_e'(action_i)),
        .edge_sel_i  (cap_edge_e'(edge_sel_i)),
        .rise_i      (rise),
        .fall_i      (fall),
        .count_i     (count_i),
        .cap_val_o   (cap_val_o),
        .pulse_val_o (pulse_val_o),
        .done_o      (done)
    );

    cap_irq_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .acc_clr_i  (acc_clr_i),
        .acc_keep_i (acc_keep_i),
        .irq_o      (irq_o)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && cap_val_o == '0 && pulse_val_o == '0));

endmodule

// File: tb/cap_pw_channel_tb.sv
module cap_pw_channel_tb;
    localparam int W = 24;
    localparam int S = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         sig = 1'b0;
    logic         en = 1'b0;
    logic [1:0]   act = 2'd0;
    logic [1:0]   edg = 2'd0;
    logic         clr = 1'b0;
    logic         keep = 1'b0;
    logic [W-1:0] cap_val;
    logic [W-1:0] pulse_val;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit started  = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cap_pw_channel #(.CNT_W(W), .SYNC_STAGES(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .sig_i(sig),
        .enable_i(en), .action_i(act), .edge_sel_i(edg),
        .acc_clr_i(clr), .acc_keep_i(keep),
        .cap_val_o(cap_val), .pulse_val_o(pulse_val), .irq_o(irq));

    // Behavioural reference model, evaluated on every rising edge.
    bit           hist[$];
    logic [W-1:0] m_cap, m_pipe, m_ref;
    bit           m_arm, m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i <= S; i++) hist.push_back(1'b0);
            m_cap = '0; m_pipe = '0; m_ref = '0; m_arm = 0; m_irq = 0;
        end else begin
            bit r, f, sel, st, fin, done;
            r = hist[S-1] && !hist[S];
            f = !hist[S-1] && hist[S];
            sel = (edg == 2'd0 && r) || (edg == 2'd1 && f) || (edg == 2'd2 && (r || f));
            st  = sel;
            fin = (edg == 2'd0 && f) || (edg == 2'd1 && r) || (edg == 2'd2 && (r || f));
            done = 0;
            if (!en) begin
                m_arm = 0;
            end else if (act == 2'd0) begin
                if (sel) begin m_cap = cnt; done = 1; end
            end else if (act == 2'd1) begin
                if (sel) begin
                    if (m_arm) begin m_cap = cnt - m_ref; done = 1; end
                    m_ref = cnt; m_arm = 1;
                end
            end else if (act == 2'd2) begin
                if (fin && m_arm) begin
                    m_pipe = cnt - m_ref; m_cap = cnt; m_arm = 0; done = 1;
                end
                if (st) begin m_ref = cnt; m_arm = 1; end
            end
            m_irq = done || (m_irq && !clr);
            hist.push_front(sig);
            void'(hist.pop_back());
        end
    end

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Cycle-by-cycle comparison with the model (R4 capture, R6 width, R9 flag).
    always @(negedge clk) begin
        if (started && !finished) begin
            check("R4 model cap", cap_val, m_cap);
            check("R6 model width", pulse_val, m_pipe);
            check("R9 model irq", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
        end
    end

    task automatic step();
        @(negedge clk);
        cnt = cnt + 1'b1;
    endtask

    task automatic hold(input bit v, input int n);
        step();
        sig = v;
        for (int i = 1; i < n; i++) step();
    endtask

    task automatic setsig(input bit v, output logic [W-1:0] c);
        step();
        sig = v;
        c = cnt;
    endtask

    task automatic settle();
        for (int i = 0; i <= S; i++) step();
    endtask

    task automatic clear_irq();
        step(); clr = 1'b1;
        step(); clr = 1'b0;
    endtask

    task automatic reconfig(input logic [1:0] a, input logic [1:0] e);
        step(); en = 1'b0;
        step(); act = a; edg = e;
        step(); en = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] c0;
        logic [W-1:0] snap_cap;
        logic [W-1:0] snap_pw;

        repeat (4) step();
        started = 1'b1;
        check("R1 reset cap", cap_val, '0);
        check("R1 reset width", pulse_val, '0);
        check("R1 reset irq", {{(W-1){1'b0}}, irq}, '0);
        step(); rst_n = 1'b1;
        repeat (3) step();

        // R2 / R4: plain capture on rising edge, exact latency
        step(); en = 1'b1; act = 2'd0; edg = 2'd0;
        repeat (3) step();
        setsig(1'b1, c0);
        settle();
        check("R2 latency", cap_val, c0 + S);
        check("R4 irq set", {{(W-1){1'b0}}, irq}, 1);
        clear_irq();
        check("R9 clear access", {{(W-1){1'b0}}, irq}, 0);

        // R3: falling edge ignored with rising selection
        setsig(1'b0, c0);
        settle();
        check("R3 unselected fall", cap_val, c0 - 1'b1 - (S + 3) + S);
        check("R3 unselected irq", {{(W-1){1'b0}}, irq}, 0);

        // R3: falling selection
        reconfig(2'd0, 2'd1);
        setsig(1'b1, c0);
        settle();
        snap_cap = cap_val;
        check("R3 rise ignored irq", {{(W-1){1'b0}}, irq}, 0);
        setsig(1'b0, c0);
        settle();
        check("R3 falling capture", cap_val, c0 + S);

        // R9: non-clearing access keeps the flag
        step(); keep = 1'b1;
        step(); keep = 1'b0;
        check("R9 keep access", {{(W-1){1'b0}}, irq}, 1);
        clear_irq();

        // R3: no-edge selection
        reconfig(2'd0, 2'd3);
        snap_cap = cap_val;
        hold(1'b1, 5); hold(1'b0, 5);
        check("R3 none selected", cap_val, snap_cap);
        check("R3 none irq", {{(W-1){1'b0}}, irq}, 0);

        // R4: reserved action has no effect
        reconfig(2'd3, 2'd2);
        hold(1'b1, 5); hold(1'b0, 5);
        check("R4 reserved action", cap_val, snap_cap);

        // R7 / R5: period measurement with arming
        reconfig(2'd1, 2'd0);
        hold(1'b1, 6);
        check("R7 first edge arms only", cap_val, snap_cap);
        check("R7 no irq on arm", {{(W-1){1'b0}}, irq}, 0);
        hold(1'b0, 4); hold(1'b1, 6);
        check("R5 period", cap_val, 10);
        hold(1'b0, 4);

        // R5: period across counter wrap
        cnt = {W{1'b1}} - 3;
        hold(1'b1, 6); hold(1'b0, 4); hold(1'b1, 6);
        check("R5 period over wrap", cap_val, 10);
        hold(1'b0, 6);

        // R6: high phase width
        reconfig(2'd2, 2'd0);
        hold(1'b1, 7); hold(1'b0, 13);
        check("R6 high width", pulse_val, 7);

        // R6 / R7: low phase width, leading rise ignored
        reconfig(2'd2, 2'd1);
        clear_irq();
        hold(1'b1, 7);
        check("R7 end edge unarmed", {{(W-1){1'b0}}, irq}, 0);
        hold(1'b0, 13); hold(1'b1, 7);
        check("R6 low width", pulse_val, 13);

        // R6: both phases
        reconfig(2'd2, 2'd2);
        hold(1'b0, 5); hold(1'b1, 9);
        check("R6 both low", pulse_val, 5);
        hold(1'b0, 4);
        check("R6 both high", pulse_val, 9);

        // R8: disabled channel holds
        clear_irq();
        step(); en = 1'b0;
        snap_cap = cap_val; snap_pw = pulse_val;
        hold(1'b1, 5); hold(1'b0, 5);
        check("R8 cap held", cap_val, snap_cap);
        check("R8 width held", pulse_val, snap_pw);
        check("R8 no irq", {{(W-1){1'b0}}, irq}, 0);

        // R10: result and clear on the same edge
        reconfig(2'd0, 2'd0);
        setsig(1'b1, c0);
        for (int i = 1; i < S; i++) step();
        step(); clr = 1'b1;
        step(); clr = 1'b0;
        check("R10 set beats clear", {{(W-1){1'b0}}, irq}, 1);
        check("R10 capture value", cap_val, c0 + S);

        repeat (4) step();
        finish_run();
    end
endmodule